// File: doc/BRIEF.md
# DMA Channel Condition Register Block

This block is the register file of one descriptor-driven DMA channel. Software reaches it through a simple 32-bit register bus: address, write strobe, write data, read strobe and registered read data. It holds a 16-bit channel status word, a command pointer, and three condition-select registers.

The lower status byte follows an 8-bit device status input. The upper status byte is owned by software and can only be changed through a separate control register. In a control write, the upper half of the written word is a per-bit write mask.

Each select register holds an 8-bit mask and an 8-bit match value. These are compared against the sampled device status bits. The three registered comparison results drive the interrupt, branch and wait condition outputs, which a descriptor engine samples.

Top module: `dma_cond_regs`

## Requirements
- R1: While `rst_n` is low and after its release, with no bus traffic, every register reads as zero, `reg_rdata` is zero and all three condition outputs are 1.
- R2: A write to offset 0x00 updates status bit 8+i to `reg_wdata[8+i]` only where `reg_wdata[24+i]` is 1, for i in 0..7. The other software status bits keep their value.
- R3: Reading offset 0x04 returns the software byte in bits [15:8] and the device input sampled on the previous edge in bits [7:0], with bits [31:16] zero. Mask bits [23:16] of a control write have no effect on bits [7:0].
- R4: Offset 0x00 always reads as zero. A write to offset 0x04 changes nothing.
- R5: Offset 0x0C is a read/write command pointer whose bits [3:0] always read as zero.
- R6: Offsets 0x10, 0x14 and 0x18 are select registers. Each stores a mask from bits [23:16] and a value from bits [7:0], and reads bits [31:24] and [15:8] as zero.
- R7: Each condition output equals ((mask AND sampled device status) == value), registered. It changes one edge after a change of the sampled status or of its select register.
- R8: `cond_irq` uses the select at 0x10, `cond_branch` the one at 0x14 and `cond_wait` the one at 0x18, independently.
- R9: `reg_rdata` is loaded on an edge where `reg_rd` is 1, with the addressed register's value before any write in that cycle. Unmapped offsets read zero, and `reg_rdata` holds while `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| dev_status | input | 8 | Device-dependent status bits |
| cond_irq | output | 1 | Interrupt condition |
| cond_branch | output | 1 | Branch condition |
| cond_wait | output | 1 | Wait condition |

## Verification
The bench goes after partial control masks. A design that ignored the mask would overwrite software bits it should keep. A design that let mask bits [23:16] reach the device byte would disturb the status that follows the input.

It also reads and writes the same register in one cycle, to catch read data that shows the new value too early. It moves the device status and the select values on neighbouring edges, so a comparator wired to the raw input or left unregistered shows up one cycle off.

Writes to the status offset, unmapped offsets and the reserved select bytes are read back, to expose any state they leak into.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int REG_AW     = 8;
  localparam int DW         = 32;
  localparam int DEV_W      = 8;
  localparam int SW_W       = 8;
  localparam int ALIGN_LSB  = 4;
  localparam int NUM_SEL    = 3;
  localparam int SEL_STRIDE = 4;
  localparam int MASK_LSB   = 16;

  localparam logic [REG_AW-1:0] OFF_CTRL     = 8'h00;
  localparam logic [REG_AW-1:0] OFF_STAT     = 8'h04;
  localparam logic [REG_AW-1:0] OFF_CPTR     = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_SEL_BASE = 8'h10;

  typedef enum logic [1:0] {
    SEL_IRQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_WAIT = 2'd2
  } sel_idx_e;

  typedef struct packed {
    logic [DEV_W-1:0] mask;
    logic [DEV_W-1:0] val;
  } sel_cfg_t;
endpackage

// File: rtl/dmacr_status.sv
module dmacr_status
  import dmacr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [DW-1:0]    ctrl_wdata,
  input  logic [DEV_W-1:0] dev_in,
  output logic [DEV_W-1:0] dev_q,
  output logic [SW_W-1:0]  sw_q
);
  localparam int WMASK_LSB = MASK_LSB + DEV_W;

  logic [SW_W-1:0] wmask;
  logic [SW_W-1:0] sw_d;

  always_comb begin
    wmask = ctrl_we ? ctrl_wdata[WMASK_LSB +: SW_W] : '0;
    sw_d  = (sw_q & ~wmask) | (ctrl_wdata[DEV_W +: SW_W] & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      dev_q <= '0;
    end else begin
      sw_q  <= sw_d;
      dev_q <= dev_in;
    end
  end
endmodule

// File: rtl/dmacr_select.sv
module dmacr_select
  import dmacr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  input  logic [DEV_W-1:0] dev_q,
  output sel_cfg_t         cfg_q,
  output logic             cond_q
);
  sel_cfg_t cfg_d;
  logic     cond_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.mask = wdata[MASK_LSB +: DEV_W];
      cfg_d.val  = wdata[0 +: DEV_W];
    end
    cond_d = ((cfg_q.mask & dev_q) == cfg_q.val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cond_q <= 1'b1;
    end else begin
      cfg_q  <= cfg_d;
      cond_q <= cond_d;
    end
  end
endmodule

// File: rtl/dmacr_rdport.sv
module dmacr_rdport
  import dmacr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd,
  input  logic [REG_AW-1:0]     addr,
  input  logic [SW_W-1:0]       sw_q,
  input  logic [DEV_W-1:0]      dev_q,
  input  logic [DW-1:0]         cptr_q,
  input  sel_cfg_t [NUM_SEL-1:0] cfgs,
  output logic [DW-1:0]         rdata_q
);
  logic [DW-1:0] mux;
  logic [DW-1:0] rdata_d;

  always_comb begin
    mux = '0;
    if (addr == OFF_STAT) begin
      mux[DEV_W-1:0]         = dev_q;
      mux[DEV_W +: SW_W]     = sw_q;
    end else if (addr == OFF_CPTR) begin
      mux = cptr_q;
    end else begin
      for (int i = 0; i < NUM_SEL; i++) begin
        if (addr == OFF_SEL_BASE + REG_AW'(i * SEL_STRIDE)) begin
          mux[MASK_LSB +: DEV_W] = cfgs[i].mask;
          mux[0 +: DEV_W]        = cfgs[i].val;
        end
      end
    end
    rdata_d = rd ? mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/dma_cond_regs.sv
module dma_cond_regs
  import dmacr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DEV_W-1:0]  dev_status,
  output logic              cond_irq,
  output logic              cond_branch,
  output logic              cond_wait
);
  localparam logic [DW-1:0] ALIGN_MASK = ~DW'((1 << ALIGN_LSB) - 1);

  logic [DEV_W-1:0]       dev_q;
  logic [SW_W-1:0]        sw_q;
  logic [DW-1:0]          cptr_q;
  logic [DW-1:0]          cptr_d;
  sel_cfg_t [NUM_SEL-1:0] sel_cfg;
  logic [NUM_SEL-1:0]     sel_cond;
  logic                   ctrl_we;

  assign ctrl_we = reg_wr && (reg_addr == OFF_CTRL);

  dmacr_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (reg_wdata),
    .dev_in     (dev_status),
    .dev_q      (dev_q),
    .sw_q       (sw_q)
  );

  always_comb begin
    cptr_d = cptr_q;
    if (reg_wr && (reg_addr == OFF_CPTR)) cptr_d = reg_wdata & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cptr_q <= '0;
    else        cptr_q <= cptr_d;
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    logic sel_we;
    assign sel_we = reg_wr && (reg_addr == OFF_SEL_BASE + REG_AW'(g * SEL_STRIDE));
    dmacr_select u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (sel_we),
      .wdata  (reg_wdata),
      .dev_q  (dev_q),
      .cfg_q  (sel_cfg[g]),
      .cond_q (sel_cond[g])
    );
  end

  dmacr_rdport u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .sw_q    (sw_q),
    .dev_q   (dev_q),
    .cptr_q  (cptr_q),
    .cfgs    (sel_cfg),
    .rdata_q (reg_rdata)
  );

  assign cond_irq    = sel_cond[SEL_IRQ];
  assign cond_branch = sel_cond[SEL_BR];
  assign cond_wait   = sel_cond[SEL_WAIT];
endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk
  import dmacr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [REG_AW-1:0]      reg_addr,
  input logic                   reg_rd,
  input logic [DW-1:0]          reg_rdata,
  input logic [DEV_W-1:0]       dev_q,
  input sel_cfg_t [NUM_SEL-1:0] cfgs,
  input logic                   c_irq,
  input logic                   c_br,
  input logic                   c_wait
);
  // R4
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CTRL) |=> (reg_rdata == '0));

  // R5
  cptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CPTR) |=> (reg_rdata[ALIGN_LSB-1:0] == '0));

  // R6
  sel_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == 8'h10 || reg_addr == 8'h14 || reg_addr == 8'h18))
      |=> (reg_rdata[31:24] == '0 && reg_rdata[15:8] == '0));

  // R3
  stat_dev_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_STAT)
      |=> (reg_rdata[7:0] == $past(dev_q) && reg_rdata[31:16] == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R7
  irq_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (c_irq == $past((cfgs[SEL_IRQ].mask & dev_q) == cfgs[SEL_IRQ].val)));

  // R8
  branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (c_br == $past((cfgs[SEL_BR].mask & dev_q) == cfgs[SEL_BR].val)));

  // R8
  wait_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (c_wait == $past((cfgs[SEL_WAIT].mask & dev_q) == cfgs[SEL_WAIT].val)));
endmodule

bind dma_cond_regs dmacr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .dev_q     (dev_q),
  .cfgs      (sel_cfg),
  .c_irq     (cond_irq),
  .c_br      (cond_branch),
  .c_wait    (cond_wait)
);

// File: tb/dma_cond_regs_bench.sv
module dma_cond_regs_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        reg_rd;
  logic [31:0] reg_rdata;
  logic [7:0]  dev_status;
  logic        cond_irq, cond_branch, cond_wait;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dma_cond_regs u_dma_cond_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .dev_status(dev_status), .cond_irq(cond_irq), .cond_branch(cond_branch),
    .cond_wait(cond_wait)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference state
  bit [7:0]  m_sw, m_dev;
  bit [31:0] m_cp, m_rd;
  bit [7:0]  m_mask [3];
  bit [7:0]  m_val  [3];
  bit        m_cond [3];
  bit [7:0]  m_last_addr;

  function automatic bit [31:0] model_read(bit [7:0] a);
    if (a == 8'h04) return {16'h0, m_sw, m_dev};
    if (a == 8'h0C) return m_cp;
    for (int i = 0; i < 3; i++)
      if (a == 8'h10 + 8'(4 * i)) return {8'h0, m_mask[i], 8'h0, m_val[i]};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = 0; m_dev = 0; m_cp = 0; m_rd = 0; m_last_addr = 8'hFF;
      for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_val[i] = 0; m_cond[i] = 1; end
    end else begin
      bit [31:0] rv;
      rv = model_read(reg_addr);
      for (int i = 0; i < 3; i++) m_cond[i] = ((m_mask[i] & m_dev) == m_val[i]);
      if (reg_wr) begin
        if (reg_addr == 8'h00)
          for (int k = 0; k < 8; k++) if (reg_wdata[24 + k]) m_sw[k] = reg_wdata[8 + k];
        if (reg_addr == 8'h0C) m_cp = reg_wdata & 32'hFFFF_FFF0;
        for (int i = 0; i < 3; i++)
          if (reg_addr == 8'h10 + 8'(4 * i)) begin
            m_mask[i] = reg_wdata[23:16]; m_val[i] = reg_wdata[7:0];
          end
      end
      if (reg_rd) begin m_rd = rv; m_last_addr = reg_addr; end
      m_dev = dev_status;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (m_last_addr)
        8'h00:                chk("R4 control reads zero", reg_rdata, m_rd);
        8'h04:                chk("R2/R3 status readback", reg_rdata, m_rd);
        8'h0C:                chk("R5 command pointer", reg_rdata, m_rd);
        8'h10, 8'h14, 8'h18:  chk("R6 select readback", reg_rdata, m_rd);
        default:              chk("R9 read data", reg_rdata, m_rd);
      endcase
      chk("R7 R8 cond_irq",    {31'h0, cond_irq},    {31'h0, m_cond[0]});
      chk("R7 R8 cond_branch", {31'h0, cond_branch}, {31'h0, m_cond[1]});
      chk("R7 R8 cond_wait",   {31'h0, cond_wait},   {31'h0, m_cond[2]});
    end
  end

  task automatic op(bit wr, bit rd, bit [7:0] a, bit [31:0] d);
    @(posedge clk); #2;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d); op(1, 0, a, d); endtask
  task automatic rd(bit [7:0] a); op(0, 1, a, 32'h0); endtask
  task automatic idle(); op(0, 0, 8'h00, 32'h0); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; dev_status = 8'h5A;
    repeat (3) @(posedge clk);
    #4;
    // R1: values held in reset
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset conds", {29'h0, cond_wait, cond_branch, cond_irq}, 32'h7);
    @(posedge clk); #2; rst_n = 1;
    dev_status = 8'h00;
    // R1: every register reads zero after reset
    rd(8'h04); rd(8'h0C); rd(8'h10); rd(8'h14); rd(8'h18); rd(8'h00);
    // R2: full and partial masks
    wr(8'h00, 32'hFF00_A500); rd(8'h04);
    wr(8'h00, 32'h0F00_FF00); rd(8'h04);
    wr(8'h00, 32'h0100_0000); rd(8'h04);
    // R3: device byte follows input, low mask ignored
    dev_status = 8'hC3; idle();
    wr(8'h00, 32'h00FF_00FF); rd(8'h04);
    // R4: status offset write ignored, control reads zero
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04); rd(8'h00);
    // R5
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C);
    wr(8'h0C, 32'h1234_567B); rd(8'h0C);
    // R6, R7, R8: selects
    wr(8'h10, 32'hFFF0_FFC0); rd(8'h10);
    wr(8'h14, 32'h0001_0001); rd(8'h14);
    wr(8'h18, 32'h0003_0003); rd(8'h18);
    dev_status = 8'h01; idle(); idle();
    dev_status = 8'h03; idle(); idle();
    dev_status = 8'hC0; idle(); idle();
    // R9: unmapped offsets and read during write
    wr(8'h08, 32'hDEAD_BEEF); rd(8'h08); rd(8'h1C);
    op(1, 1, 8'h0C, 32'hAAAA_5550); rd(8'h0C);
    op(1, 1, 8'h10, 32'h0000_0000); idle(); idle();
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] a;
      case ($urandom_range(0, 8))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h0C; 3: a = 8'h10;
        4: a = 8'h14; 5: a = 8'h18; 6: a = 8'h08; 7: a = 8'h1C;
        default: a = 8'(($urandom_range(0, 63)) << 2);
      endcase
      if ($urandom_range(0, 3) == 0) dev_status = 8'($urandom());
      op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, $urandom());
    end
    idle(); idle();
    @(posedge clk); #6;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule